// File: doc/BRIEF.md
# DMA Burst Read Requester

This block drives the request half of a handshake channel between a peripheral and a DMA controller. The local logic holds a level input high while it wants data. The block turns that level into one burst request on a valid/ready request channel, then stays silent until the controller confirms the burst. After that confirmation it asks again if the level is still high.

The controller can also send commands on an acknowledge channel that is always ready. A confirmation of kind single is ignored. A flush command is answered with a flush reply on the request channel in the next cycle, whether or not a burst is outstanding. When a flush reply and a new burst request would start in the same cycle, the flush reply goes out first.

Both channels carry a two-bit kind code: burst = 0, single = 1, flush = 2. Code 3 on the acknowledge channel is ignored.

Top module: `dmareq_burst_requester`

## Requirements
- R1: `ak_ready_o` is 1 in every cycle, including during and right after reset.
- R2: While reset is applied, and in the first cycle after it, `rq_valid_o` is 0.
- R3: `rq_valid_o` is 0 in the cycle after an edge at which all of these hold: `burst_want_i` is low, no flush reply is owed, and no request is waiting for ready.
- R4: The block is idle when it has no outstanding burst, no owed flush and no request on the channel. If `burst_want_i` is high at a clock edge while the block is idle, then after that edge `rq_valid_o` is 1 and `rq_kind_o` is 0 (burst).
- R5: A burst is outstanding from the edge at which it is taken (`rq_valid_o` and `rq_ready_i` both high, kind 0). While it is outstanding, no further burst request is shown, for any number of cycles.
- R6: An acknowledge of kind 0 (burst) clears the outstanding burst. If `burst_want_i` is high at that edge, a new burst request appears after that edge.
- R7: An acknowledge of kind 1 (single), or of the unused code 3, changes nothing. The request output stays as it would be without it, across any number of such acknowledges.
- R8: An acknowledge of kind 2 (flush) makes `rq_valid_o` 1 with `rq_kind_o` 2 after that edge. This holds when the block is idle and when a burst is outstanding. With `rq_ready_i` high, the reply lasts exactly one cycle and does not mark a burst as outstanding.
- R9: If a flush reply and a burst request would start at the same edge, the flush reply is shown first. The burst request follows after the flush reply is taken.
- R10: While `rq_valid_o` is 1 and `rq_ready_i` is 0, `rq_valid_o` and `rq_kind_o` hold their values. A flush command that arrives during such a stall is kept and answered after the stalled request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_want_i | input | 1 | Level from local logic asking for burst transfers |
| rq_valid_o | output | 1 | Request channel valid |
| rq_ready_i | input | 1 | Request channel ready from the controller |
| rq_kind_o | output | 2 | Request kind: 0 burst, 2 flush |
| ak_valid_i | input | 1 | Acknowledge channel valid from the controller |
| ak_kind_i | input | 2 | Acknowledge kind: 0 burst, 1 single, 2 flush |
| ak_ready_o | output | 1 | Acknowledge channel ready, always 1 |

## Verification
The hardest case to reach is a flush command that arrives while a burst request is stalled on a low ready. The block must keep the flush until the stalled request is taken, and only then reply with the flush ahead of any new burst. Random stimulus alone rarely lines these events up. A directed sequence therefore drops ready, issues a flush acknowledge during the stall, and then releases ready. Long random runs with biased ready and acknowledge rates then cover the remaining mixes of stall, single and flush traffic.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_BURST  = 2'd0,
    KIND_SINGLE = 2'd1,
    KIND_FLUSH  = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;
endpackage

// File: rtl/dmareq_ack_decode.sv
module dmareq_ack_decode
  import dmareq_pkg::*;
(
  input  logic              ak_valid,
  input  logic [KIND_W-1:0] ak_kind,
  output logic              ak_burst,
  output logic              ak_flush
);
  // single and reserved codes decode to nothing
  always_comb begin
    ak_burst = 1'b0;
    ak_flush = 1'b0;
    if (ak_valid) begin
      unique case (kind_e'(ak_kind))
        KIND_BURST: ak_burst = 1'b1;
        KIND_FLUSH: ak_flush = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dmareq_outstanding.sv
module dmareq_outstanding
  import dmareq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rq_valid,
  input  logic              rq_ready,
  input  logic [KIND_W-1:0] rq_kind,
  input  logic              ak_burst,
  output logic              busy_q,
  output logic              busy_next
);
  logic taken_burst;

  assign taken_burst = rq_valid && rq_ready && (kind_e'(rq_kind) == KIND_BURST);
  assign busy_next   = (busy_q && !ak_burst) || taken_burst;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_next;
  end

  // R5: no burst request is shown while one is outstanding
  assert_quiet_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !(rq_valid && kind_e'(rq_kind) == KIND_BURST));

  // R6: a burst acknowledge releases the outstanding flag
  assert_release_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ak_burst && !rq_valid) |=> !busy_q);
endmodule

// File: rtl/dmareq_flush_owed.sv
module dmareq_flush_owed (
  input  logic clk,
  input  logic rst,
  input  logic ak_flush,
  input  logic stalled,
  output logic owed_q
);
  // a flush is parked only when the output register cannot load it now
  always_ff @(posedge clk) begin
    if (rst)            owed_q <= 1'b0;
    else if (stalled)   owed_q <= owed_q || ak_flush;
    else                owed_q <= 1'b0;
  end

  // R10: a flush that arrives during a stall is remembered
  assert_park_in_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (stalled && ak_flush) |=> owed_q);
endmodule

// File: rtl/dmareq_issuer.sv
module dmareq_issuer
  import dmareq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              want,
  input  logic              rq_ready,
  input  logic              ak_flush,
  input  logic              owed_q,
  input  logic              busy_next,
  output logic              stalled,
  output logic              rq_valid_q,
  output logic [KIND_W-1:0] rq_kind_q
);
  logic flush_now;

  assign stalled   = rq_valid_q && !rq_ready;
  assign flush_now = ak_flush || owed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_valid_q <= 1'b0;
      rq_kind_q  <= KIND_BURST;
    end else if (!stalled) begin
      if (flush_now) begin
        rq_valid_q <= 1'b1;
        rq_kind_q  <= KIND_FLUSH;
      end else if (want && !busy_next) begin
        rq_valid_q <= 1'b1;
        rq_kind_q  <= KIND_BURST;
      end else begin
        rq_valid_q <= 1'b0;
      end
    end
  end

  // R10: a stalled request holds valid and kind
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    stalled |=> (rq_valid_q && $stable(rq_kind_q)));

  // R8: a flush command is answered on the next cycle when not stalled
  assert_flush_reply_R8: assert property (@(posedge clk) disable iff (rst)
    (ak_flush && !stalled) |=> (rq_valid_q && kind_e'(rq_kind_q) == KIND_FLUSH));

  // R3: nothing wanted and nothing owed gives an empty channel
  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!want && !flush_now && !stalled) |=> !rq_valid_q);

  // R9: a parked flush is served before any burst
  assert_flush_first_R9: assert property (@(posedge clk) disable iff (rst)
    (owed_q && !stalled) |=> (kind_e'(rq_kind_q) == KIND_FLUSH));
endmodule

// File: rtl/dmareq_burst_requester.sv
module dmareq_burst_requester
  import dmareq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_want_i,
  output logic              rq_valid_o,
  input  logic              rq_ready_i,
  output logic [KIND_W-1:0] rq_kind_o,
  input  logic              ak_valid_i,
  input  logic [KIND_W-1:0] ak_kind_i,
  output logic              ak_ready_o
);
  logic ak_burst, ak_flush;
  logic busy_q, busy_next;
  logic owed_q, stalled;

  assign ak_ready_o = 1'b1;

  dmareq_ack_decode u_dec (
    .ak_valid (ak_valid_i),
    .ak_kind  (ak_kind_i),
    .ak_burst (ak_burst),
    .ak_flush (ak_flush)
  );

  dmareq_outstanding u_busy (
    .clk       (clk),
    .rst       (rst),
    .rq_valid  (rq_valid_o),
    .rq_ready  (rq_ready_i),
    .rq_kind   (rq_kind_o),
    .ak_burst  (ak_burst),
    .busy_q    (busy_q),
    .busy_next (busy_next)
  );

  dmareq_flush_owed u_owed (
    .clk      (clk),
    .rst      (rst),
    .ak_flush (ak_flush),
    .stalled  (stalled),
    .owed_q   (owed_q)
  );

  dmareq_issuer u_iss (
    .clk        (clk),
    .rst        (rst),
    .want       (burst_want_i),
    .rq_ready   (rq_ready_i),
    .ak_flush   (ak_flush),
    .owed_q     (owed_q),
    .busy_next  (busy_next),
    .stalled    (stalled),
    .rq_valid_q (rq_valid_o),
    .rq_kind_q  (rq_kind_o)
  );

  // R1: the acknowledge channel never back-pressures
  assert_ack_ready_R1: assert property (@(posedge clk) ak_ready_o);

  // R4: an idle block answers a raised want with a burst request
  assert_start_burst_R4: assert property (@(posedge clk) disable iff (rst)
    (burst_want_i && !busy_q && !owed_q && !rq_valid_o && !ak_valid_i)
      |=> (rq_valid_o && kind_e'(rq_kind_o) == KIND_BURST));
endmodule

// File: tb/dmareq_burst_requester_test.sv
`timescale 1ns/1ps
module dmareq_burst_requester_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       want;
  logic       rq_valid;
  logic       rq_ready;
  logic [1:0] rq_kind;
  logic       ak_valid;
  logic [1:0] ak_kind;
  logic       ak_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench reference state
  bit       m_valid;
  bit [1:0] m_kind;
  bit       m_busy;
  bit       m_owed;

  always #2 clk = ~clk;

  dmareq_burst_requester uut (
    .clk          (clk),
    .rst          (rst),
    .burst_want_i (want),
    .rq_valid_o   (rq_valid),
    .rq_ready_i   (rq_ready),
    .rq_kind_o    (rq_kind),
    .ak_valid_i   (ak_valid),
    .ak_kind_i    (ak_kind),
    .ak_ready_o   (ak_ready)
  );

  function automatic bit exp_busy(bit busy, bit v, bit [1:0] k, bit rdy,
                                  bit av, bit [1:0] ak);
    return (busy && !(av && ak == 2'd0)) || (v && rdy && k == 2'd0);
  endfunction

  task automatic advance(bit w, bit rdy, bit av, bit [1:0] ak);
    bit nb, af, st;
    af = av && (ak == 2'd2);
    st = m_valid && !rdy;
    nb = exp_busy(m_busy, m_valid, m_kind, rdy, av, ak);
    if (st) begin
      m_owed = m_owed || af;
    end else if (af || m_owed) begin
      m_valid = 1; m_kind = 2'd2; m_owed = 0;
    end else if (w && !nb) begin
      m_valid = 1; m_kind = 2'd0;
    end else begin
      m_valid = 0;
    end
    m_busy = nb;
  endtask

  task automatic compare(string tag);
    n_chk++;
    if (rq_valid !== m_valid || (m_valid && rq_kind !== m_kind) || ak_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: valid=%0d kind=%0d ready=%0d expected valid=%0d kind=%0d ready=1",
               tag, rq_valid, rq_kind, ak_ready, m_valid, m_kind);
    end
  endtask

  // compare state left by the last edge, drive new inputs, take one edge
  task automatic cyc(string tag, bit w, bit rdy, bit av, bit [1:0] ak);
    @(negedge clk);
    compare(tag);
    want = w; rq_ready = rdy; ak_valid = av; ak_kind = ak;
    @(posedge clk);
    advance(w, rdy, av, ak);
  endtask

  initial begin
    rst = 1; want = 0; rq_ready = 0; ak_valid = 0; ak_kind = 0;
    m_valid = 0; m_kind = 0; m_busy = 0; m_owed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R2");
    compare("R1");
    rst = 0;
    @(posedge clk);
    // R2/R3: quiet after reset
    for (int i = 0; i < 4; i++) cyc("R3", 0, 1, 0, 0);
    // R4: raise want, burst request next clock; taken at once
    cyc("R4", 1, 1, 0, 0);
    cyc("R4", 1, 1, 0, 0);
    // R5: outstanding for many cycles
    for (int i = 0; i < 20; i++) cyc("R5", 1, 1, 0, 0);
    // R7: single and reserved acks change nothing
    for (int i = 0; i < 8; i++) cyc("R7", 1, 1, 1, (i % 2) ? 2'd3 : 2'd1);
    // R8: flush while outstanding, one cycle reply
    cyc("R8", 1, 1, 1, 2'd2);
    for (int i = 0; i < 4; i++) cyc("R8", 1, 1, 0, 0);
    // R6: burst ack re-arms
    cyc("R6", 1, 1, 1, 2'd0);
    for (int i = 0; i < 3; i++) cyc("R6", 1, 1, 0, 0);
    // R6: burst ack with want low gives no new request
    cyc("R6", 0, 1, 1, 2'd0);
    for (int i = 0; i < 3; i++) cyc("R6", 0, 1, 0, 0);
    // R8: flush while idle
    cyc("R8", 0, 1, 1, 2'd2);
    for (int i = 0; i < 3; i++) cyc("R8", 0, 1, 0, 0);
    // R9: flush and want start together, flush first
    cyc("R9", 1, 1, 1, 2'd2);
    for (int i = 0; i < 4; i++) cyc("R9", 1, 1, 0, 0);
    cyc("R9", 0, 1, 1, 2'd0);
    cyc("R9", 0, 1, 0, 0);
    // R10: stall a burst request, flush arrives during stall
    cyc("R10", 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R10", 1, 0, 0, 0);
    cyc("R10", 0, 0, 1, 2'd2);
    for (int i = 0; i < 3; i++) cyc("R10", 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R10", 0, 1, 0, 0);
    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      bit w, r, a;
      bit [1:0] k;
      w = ($urandom % 4) != 0;
      r = ($urandom % 3) != 0;
      a = ($urandom % 5) == 0;
      k = 2'($urandom % 4);
      cyc("R5,R6,R7,R8,R10", w, r, a, k);
    end
    @(negedge clk);
    compare("R5,R6,R8");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule